// File: doc/BRIEF.md
# Single-Bit Boolean Processing Unit

This block is a one-bit execution unit that works next to an 8-bit microcontroller datapath. Its accumulator is the carry flag. It carries out decoded bit operations on a 256-entry bit address space. The lower half of that space folds onto a 16-byte window of internal RAM that starts at byte 20H. The upper half folds onto the special function registers whose addresses are multiples of eight. The unit performs these operations on the target bit:

- set, clear, complement;
- copy into carry, copy from carry;
- AND or OR into carry, with the bit either true or complemented;
- relative branch on the bit being set or clear.

Storage is byte-wide, so every bit write is a read-modify-write. The unit reads the byte when it accepts the operation. It merges the single bit in the next cycle. It writes the byte back the cycle after that, and it takes no new operation until that write has gone out. A read-only operation occupies two cycles.

The byte storage sits outside the block. It is reached through a single read port with a one-cycle latency and a single write port. Byte addresses below 80H are internal RAM and those at 80H and above are SFRs, so a neighbour can steer each access by the address MSB.

Top module: `bitproc_unit`

## Requirements
- R1: After reset, `carry_out` is 0, `op_ready` is 1, and `wr_en` and `br_taken` are 0. Carry changes only as the result of an accepted operation. Opcodes 10, 11 and 12 set, clear and invert carry, without touching storage.
- R2: Bit addresses 00H–7FH select byte `20H + addr[6:3]` and bit position `addr[2:0]`.
- R3: Bit addresses 80H–FFH select byte `addr & F8H` and bit position `addr[2:0]`.
- R4: Opcode 1 forces the addressed bit to 1 and opcode 2 forces it to 0. The written byte keeps the other seven bits as they were read.
- R5: Opcode 3 inverts the addressed bit in place and keeps the other bits.
- R6: Opcode 4 copies the addressed bit into carry and writes nothing.
- R7: Opcode 5 writes the current carry into the addressed bit and keeps the other bits.
- R8: Opcode 6 sets carry to carry AND operand, and opcode 7 sets carry to carry OR operand. The operand is the addressed bit when `op_inv` is 0 and its complement when `op_inv` is 1.
- R9: Opcode 8 branches when the addressed bit is 1, and opcode 9 branches when it is 0. On a branch, `br_taken` pulses for one cycle with `br_target = op_pc + sign-extended op_rel` (16-bit wrap). Otherwise `br_taken` stays 0.
- R10: An operation is accepted when `op_valid` and `op_ready` are both high in cycle T, and `rd_addr`/`rd_en` present the byte in that same cycle. Results (carry, branch, write request) appear in cycle T+2 and `op_ready` is low in T+1. For opcodes 1, 2, 3 and 5, `wr_en` is high for exactly cycle T+2 and `op_ready` stays low through T+2.
- R11: Opcodes 0 and 13–15 change neither carry nor storage, request no write and do not branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_bit_addr | input | 8 | Bit address |
| op_inv | input | 1 | Use complement of bit for AND/OR into carry |
| op_rel | input | 8 | Signed relative branch offset |
| op_pc | input | 16 | Base address the offset is added to |
| op_ready | output | 1 | Unit can accept an operation |
| rd_en | output | 1 | Byte read request |
| rd_addr | output | 8 | Byte read address |
| rd_data | input | 8 | Byte read data, valid one cycle after `rd_en` |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 8 | Byte write address |
| wr_data | output | 8 | Merged byte to write |
| carry_out | output | 1 | Boolean accumulator |
| br_taken | output | 1 | Branch taken pulse |
| br_target | output | 16 | Branch destination |

## Verification
The hardest case to reach from the ports is a read-modify-write whose merged byte would be wrong in bits other than the target bit. The backing storage is therefore seeded with a dense, irregular byte pattern, so every neighbour bit has a known non-trivial value. The stimulus then hits both ends of the RAM window and several SFR slots. At the end it sweeps a copy-to-carry over all 256 bit addresses, so every bit of storage is read back through carry and compared with the bench's own shadow of memory. Branches use a negative offset that wraps below address zero.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  typedef enum logic [3:0] {
    BOP_NOP  = 4'd0,
    BOP_SETB = 4'd1,
    BOP_CLRB = 4'd2,
    BOP_CPLB = 4'd3,
    BOP_LDC  = 4'd4,
    BOP_STC  = 4'd5,
    BOP_ANDC = 4'd6,
    BOP_ORC  = 4'd7,
    BOP_JSET = 4'd8,
    BOP_JCLR = 4'd9,
    BOP_SETC = 4'd10,
    BOP_CLRC = 4'd11,
    BOP_CPLC = 4'd12
  } bop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_WB   = 2'd2
  } bstate_e;

  function automatic logic bop_reads(input bop_e op);
    case (op)
      BOP_SETB, BOP_CLRB, BOP_CPLB, BOP_LDC, BOP_STC,
      BOP_ANDC, BOP_ORC, BOP_JSET, BOP_JCLR: bop_reads = 1'b1;
      default:                               bop_reads = 1'b0;
    endcase
  endfunction

  function automatic logic bop_writes(input bop_e op);
    case (op)
      BOP_SETB, BOP_CLRB, BOP_CPLB, BOP_STC: bop_writes = 1'b1;
      default:                               bop_writes = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  RAM_BASE = 8'h20,
  localparam int         IDX_W    = $clog2(DATA_W)
) (
  input  logic [ADDR_W-1:0] bit_addr,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  bit_idx
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(RAM_BASE);

  logic [ADDR_W-1:0] ram_byte;
  logic [ADDR_W-1:0] sfr_byte;

  // lower half: packed window in RAM; upper half: aligned SFR slots
  assign ram_byte  = BASE + ADDR_W'(bit_addr[ADDR_W-2:IDX_W]);
  assign sfr_byte  = {bit_addr[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
  assign byte_addr = bit_addr[ADDR_W-1] ? sfr_byte : ram_byte;
  assign bit_idx   = bit_addr[IDX_W-1:0];

endmodule

// File: rtl/bitproc_logic.sv
module bitproc_logic
  import bitproc_pkg::*;
#(
  parameter int  DATA_W = 8,
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  bop_e               op,
  input  logic               inv,
  input  logic               carry,
  input  logic [DATA_W-1:0]  byte_in,
  input  logic [IDX_W-1:0]   bit_idx,
  output logic               carry_nxt,
  output logic [DATA_W-1:0]  byte_nxt,
  output logic               take_jump
);

  logic [DATA_W-1:0] mask;
  logic              bit_val;
  logic              operand;

  assign mask    = DATA_W'(1) << bit_idx;
  assign bit_val = byte_in[bit_idx];
  assign operand = bit_val ^ inv;

  always_comb begin
    carry_nxt = carry;
    byte_nxt  = byte_in;
    take_jump = 1'b0;
    case (op)
      BOP_SETB: byte_nxt  = byte_in | mask;
      BOP_CLRB: byte_nxt  = byte_in & ~mask;
      BOP_CPLB: byte_nxt  = byte_in ^ mask;
      BOP_STC:  byte_nxt  = carry ? (byte_in | mask) : (byte_in & ~mask);
      BOP_LDC:  carry_nxt = bit_val;
      BOP_ANDC: carry_nxt = carry & operand;
      BOP_ORC:  carry_nxt = carry | operand;
      BOP_JSET: take_jump = bit_val;
      BOP_JCLR: take_jump = ~bit_val;
      BOP_SETC: carry_nxt = 1'b1;
      BOP_CLRC: carry_nxt = 1'b0;
      BOP_CPLC: carry_nxt = ~carry;
      default:  ;
    endcase
  end

endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
  import bitproc_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter int         PC_W     = 16,
  parameter int         REL_W    = 8,
  parameter logic [7:0] RAM_BASE = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [ADDR_W-1:0] op_bit_addr,
  input  logic              op_inv,
  input  logic [REL_W-1:0]  op_rel,
  input  logic [PC_W-1:0]   op_pc,
  output logic              op_ready,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              carry_out,
  output logic              br_taken,
  output logic [PC_W-1:0]   br_target
);

  localparam int IDX_W     = $clog2(DATA_W);
  localparam int RAM_BYTES = 1 << (ADDR_W - 1 - IDX_W);

  bstate_e            state;
  bop_e               op_in;
  bop_e               op_q;
  logic               inv_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ADDR_W-1:0]  baddr_q;
  logic [PC_W-1:0]    pc_q;
  logic [REL_W-1:0]   rel_q;
  logic               carry_q;
  logic               accept;

  logic [ADDR_W-1:0]  map_byte;
  logic [IDX_W-1:0]   map_idx;
  logic               carry_nxt;
  logic [DATA_W-1:0]  byte_nxt;
  logic               take_jump;

  assign op_in    = bop_e'(op_code);
  assign op_ready = (state == ST_IDLE);
  assign accept   = op_valid && op_ready;
  assign rd_en    = accept && bop_reads(op_in);
  assign rd_addr  = map_byte;
  assign carry_out = carry_q;

  bitproc_addr_map #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RAM_BASE (RAM_BASE)
  ) i_map (
    .bit_addr  (op_bit_addr),
    .byte_addr (map_byte),
    .bit_idx   (map_idx)
  );

  bitproc_logic #(
    .DATA_W (DATA_W)
  ) i_logic (
    .op        (op_q),
    .inv       (inv_q),
    .carry     (carry_q),
    .byte_in   (rd_data),
    .bit_idx   (idx_q),
    .carry_nxt (carry_nxt),
    .byte_nxt  (byte_nxt),
    .take_jump (take_jump)
  );

  // operation capture
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= BOP_NOP;
      inv_q   <= 1'b0;
      idx_q   <= '0;
      baddr_q <= '0;
      pc_q    <= '0;
      rel_q   <= '0;
    end else if (accept) begin
      op_q    <= op_in;
      inv_q   <= op_inv;
      idx_q   <= map_idx;
      baddr_q <= map_byte;
      pc_q    <= op_pc;
      rel_q   <= op_rel;
    end
  end

  // sequencing and registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      carry_q   <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      br_taken <= 1'b0;
      wr_en    <= 1'b0;
      case (state)
        ST_IDLE: if (accept) state <= ST_EXEC;
        ST_EXEC: begin
          carry_q  <= carry_nxt;
          br_taken <= take_jump;
          if (take_jump)
            br_target <= pc_q + {{(PC_W-REL_W){rel_q[REL_W-1]}}, rel_q};
          if (bop_writes(op_q)) begin
            wr_en   <= 1'b1;
            wr_addr <= baddr_q;
            wr_data <= byte_nxt;
            state   <= ST_WB;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_carry_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (state != ST_EXEC) |=> $stable(carry_out));

  assert_ram_window_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !op_bit_addr[ADDR_W-1]) |->
      (rd_addr >= ADDR_W'(RAM_BASE) && rd_addr < ADDR_W'(RAM_BASE) + ADDR_W'(RAM_BYTES)));

  assert_sfr_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && op_bit_addr[ADDR_W-1]) |->
      (rd_addr[ADDR_W-1] && rd_addr[IDX_W-1:0] == '0));

  assert_merge_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (((wr_data ^ $past(rd_data)) & ~(DATA_W'(1) << idx_q)) == '0));

  assert_branch_from_exec_R9: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> $past(state == ST_EXEC));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    accept |=> !op_ready);

  assert_wb_single_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  assert_wb_address_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr == $past(rd_addr, 2)));

endmodule

// File: tb/test_bitproc_unit.sv
module test_bitproc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [7:0]  op_bit_addr = '0;
  logic        op_inv = 1'b0;
  logic [7:0]  op_rel = '0;
  logic [15:0] op_pc = '0;
  logic        op_ready;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data = '0;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        carry_out;
  logic        br_taken;
  logic [15:0] br_target;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic       ref_c;

  always #5 clk = ~clk;

  bitproc_unit i_bitproc_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_bit_addr(op_bit_addr), .op_inv(op_inv), .op_rel(op_rel), .op_pc(op_pc),
    .op_ready(op_ready), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .carry_out(carry_out),
    .br_taken(br_taken), .br_target(br_target)
  );

  // byte storage seen by the unit: one-cycle read latency
  always @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int byte_of(input int a);
    return (a < 128) ? (32 + a / 8) : (a & 8'hF8);
  endfunction

  task automatic do_op(input string req, input int code, input int addr,
                       input bit inv, input int rel, input int pc);
    int ba, bi;
    bit val, opnd, exp_wr, exp_take, nc;
    logic [7:0] nb;
    logic [15:0] tgt;
    ba = byte_of(addr);
    bi = addr % 8;
    val = ref_mem[ba][bi];
    opnd = val ^ inv;
    nb = ref_mem[ba];
    nc = ref_c;
    exp_wr = 0;
    exp_take = 0;
    case (code)
      1: begin nb[bi] = 1'b1; exp_wr = 1; end
      2: begin nb[bi] = 1'b0; exp_wr = 1; end
      3: begin nb[bi] = ~nb[bi]; exp_wr = 1; end
      4: nc = val;
      5: begin nb[bi] = ref_c; exp_wr = 1; end
      6: nc = ref_c & opnd;
      7: nc = ref_c | opnd;
      8: exp_take = val;
      9: exp_take = !val;
      10: nc = 1'b1;
      11: nc = 1'b0;
      12: nc = !ref_c;
      default: ;
    endcase
    tgt = 16'(pc + {{8{rel[7]}}, rel[7:0]});

    @(negedge clk);
    chk({req, " R10 ready before accept"}, op_ready, 1);
    op_valid = 1'b1; op_code = code[3:0]; op_bit_addr = addr[7:0];
    op_inv = inv; op_rel = rel[7:0]; op_pc = pc[15:0];
    @(negedge clk);
    op_valid = 1'b0;
    chk({req, " R10 busy in T+1"}, op_ready, 0);
    chk({req, " R10 no write in T+1"}, wr_en, 0);
    @(negedge clk);
    chk({req, " carry"}, carry_out, nc);
    chk({req, " branch taken"}, br_taken, exp_take);
    if (exp_take) chk({req, " R9 branch target"}, br_target, tgt);
    chk({req, " write strobe"}, wr_en, exp_wr);
    chk({req, " R10 ready in T+2"}, op_ready, !exp_wr);
    if (exp_wr) begin
      chk({req, " write address"}, wr_addr, ba);
      chk({req, " write data"}, wr_data, nb);
      ref_mem[ba] = nb;
    end
    ref_c = nc;
    if (exp_wr) begin
      @(negedge clk);
      chk({req, " R10 single write cycle"}, wr_en, 0);
      chk({req, " R10 ready after write-back"}, op_ready, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'((i * 37 + 5) ^ (i >> 2));
      ref_mem[i] = mem[i];
    end
    ref_c = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset carry", carry_out, 0);
    chk("R1 reset ready", op_ready, 1);
    chk("R1 reset write", wr_en, 0);
    chk("R1 reset branch", br_taken, 0);

    do_op("R1 set carry", 10, 0, 0, 0, 0);
    do_op("R1 invert carry", 12, 0, 0, 0, 0);
    do_op("R1 invert carry again", 12, 0, 0, 0, 0);
    do_op("R1 clear carry", 11, 0, 0, 0, 0);

    do_op("R2 R4 set low ram bit", 1, 8'h00, 0, 0, 0);
    do_op("R2 R4 set top ram bit", 1, 8'h7F, 0, 0, 0);
    do_op("R2 R4 clear ram bit", 2, 8'h13, 0, 0, 0);
    do_op("R2 R4 clear ram bit 2", 2, 8'h42, 0, 0, 0);
    do_op("R3 R4 set sfr bit", 1, 8'h85, 0, 0, 0);
    do_op("R3 R4 clear sfr bit", 2, 8'hF8, 0, 0, 0);
    do_op("R3 R5 invert sfr bit", 3, 8'hE7, 0, 0, 0);
    do_op("R2 R5 invert ram bit", 3, 8'h2C, 0, 0, 0);
    do_op("R2 R5 invert ram bit twice", 3, 8'h2C, 0, 0, 0);

    do_op("R6 load set bit", 4, 8'h7F, 0, 0, 0);
    do_op("R7 store carry one", 5, 8'h31, 0, 0, 0);
    do_op("R6 load clear bit", 4, 8'h13, 0, 0, 0);
    do_op("R7 store carry zero", 5, 8'h9E, 0, 0, 0);
    do_op("R7 store carry zero ram", 5, 8'h00, 0, 0, 0);

    do_op("R1 set carry", 10, 0, 0, 0, 0);
    do_op("R8 and true bit", 6, 8'h7F, 0, 0, 0);
    do_op("R8 and complemented bit", 6, 8'h7F, 1, 0, 0);
    do_op("R8 or complemented bit", 7, 8'h13, 1, 0, 0);
    do_op("R8 and complemented clear bit", 6, 8'h13, 1, 0, 0);
    do_op("R8 or true clear bit", 7, 8'h13, 0, 0, 0);
    do_op("R8 or true set bit", 7, 8'h85, 0, 0, 0);

    do_op("R9 jump if set taken", 8, 8'h85, 0, 8'h10, 16'h1234);
    do_op("R9 jump if set not taken", 8, 8'h13, 0, 8'h10, 16'h1234);
    do_op("R9 jump if clear taken wrap", 9, 8'h13, 0, 8'hF0, 16'h0005);
    do_op("R9 jump if clear not taken", 9, 8'h7F, 0, 8'h80, 16'h8000);
    do_op("R9 jump back", 8, 8'h00, 0, 8'h80, 16'h0100);

    do_op("R11 nop", 0, 8'h7F, 0, 0, 0);
    do_op("R11 unused 13", 13, 8'h85, 1, 0, 0);
    do_op("R11 unused 15", 15, 8'h00, 0, 0, 0);

    for (int a = 0; a < 256; a++) do_op("R2 R3 readback", 4, a, 0, 0, 0);

    finish_run();
  end

endmodule